// File: doc/BRIEF.md
# Table-Encoded Clock-Enable Divider

This block turns one of three source clock-enable strobes into a slower enable strobe. It gives out a single-cycle pulse once for every N strobes of the chosen source. The divide ratio N does not come straight from the 3-bit divide code. A 2-bit table mode picks one of four lookup rules, and that rule maps the code to a ratio between 2 and 32. Some rules give odd ratios. In some rules, codes 0 and 1 give the same ratio.

Everything runs on one clock, and each source is a strobe that is qualified on that clock. The divider latches the code, the mode and the source only at a pulse boundary. Because of this, a reprogramming never produces a shortened or stretched period. It only changes the rate from the next pulse onward. Two outputs report what the divider is applying now: the ratio and the source.

Top module: `tbl_clk_div`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), cur_ratio is 2, cur_src is 0 and div_pulse is 0. This matches mode 0 with code 0 on source 0.
- R2: Mode 0 is the doubling table: ratio = 2 x (code + 1), which spans 2 to 16.
- R3: Mode 1 is the quadrupling table: ratio = 4 x (code + 1), which spans 4 to 32.
- R4: Mode 2 is the engine table. Codes 0 and 1 both give ratio 2. Codes 2 to 7 give code + 1, which spans 3 to 8.
- R5: Mode 3 is the network table. Codes 0 and 1 both give ratio 4. Codes 2 to 7 give 2 x code, which spans 4 to 14.
- R6: div_pulse is high for exactly one clock in every cur_ratio strobes of the applied source. The pulse appears in the cycle after the clock edge at which the last of those strobes is sampled.
- R7: A change on div_code, tbl_mode or src_sel takes effect only at a pulse boundary. cur_ratio and cur_src change only in a cycle where div_pulse is high. The period that is running when the change arrives completes at its old length.
- R8: src_sel values 0 to 2 select src_tick bit 0 to 2. Value 3 is invalid: at a boundary it leaves cur_src on the previously applied source.
- R9: The counter advances only on clocks where the applied source's strobe is high. Strobes on the other two sources have no effect. No pulse is produced while the applied strobe stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 3 | Enable strobes of the three candidate sources |
| src_sel | input | 2 | Requested source (0 to 2; 3 is ignored) |
| div_code | input | 3 | Divide code, translated through the table |
| tbl_mode | input | 2 | Table mode: 0 doubling, 1 quadrupling, 2 engine, 3 network |
| div_pulse | output | 1 | One-cycle divided enable pulse |
| cur_ratio | output | 6 | Divide ratio applied now |
| cur_src | output | 2 | Source applied now |

## Verification
Corrupted count state shows up as a pulse spacing that is off by at least one strobe, and it is visible at the next pulse. A wrong table entry shows up in cur_ratio in the cycle of the first pulse after the code is applied. A boundary update that leaks into mid-period reveals itself as cur_ratio or cur_src moving while div_pulse is low, or as one shortened period right after a reprogramming. A wrong source pick appears as pulses driven by strobes that should be ignored. The bench drives every mode and code directly and measures each period. It then runs random strobe patterns and reprogramming against a cycle-level model, so any of these faults is seen within one period of 32 strobes or less.

// File: rtl/tbl_clk_div_pkg.sv
// Shared types and constants for the table-encoded clock-enable divider.
// Assumes the four table rules and the reset point described in the brief.
package tbl_clk_div_pkg;

    // Table rule selected by the mode input; the encoding is architectural.
    typedef enum logic [1:0] {
        TBL_DOUBLE  = 2'd0,
        TBL_QUAD    = 2'd1,
        TBL_ENGINE  = 2'd2,
        TBL_NETWORK = 2'd3
    } tbl_mode_e;

    localparam int NUM_MODES     = 4;
    localparam int RESET_RATIO   = 2;   // doubling rule, code 0
    localparam int RESET_SOURCE  = 0;

endpackage

// File: rtl/cdiv_ratio_lut.sv
// cdiv_ratio_lut: translates a divide code into a ratio through the rule that
// the table mode picks. It is purely combinational. Every rule has its own
// generated branch, and the mode index then chooses among the candidates.
// Assumes RATIO_W is wide enough to hold 4 * 2**CODE_W.
module cdiv_ratio_lut
    import tbl_clk_div_pkg::*;
#(
    parameter int CODE_W  = 3,
    parameter int RATIO_W = 6
) (
    input  logic [CODE_W-1:0]  code,
    input  tbl_mode_e          mode,
    output logic [RATIO_W-1:0] ratio
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);
    localparam logic [RATIO_W-1:0] TWO = RATIO_W'(2);
    localparam logic [RATIO_W-1:0] FOUR = RATIO_W'(4);

    logic [RATIO_W-1:0] code_ext;
    logic [RATIO_W-1:0] cand [NUM_MODES];

    // Widen the code once so that each rule does its arithmetic at ratio width.
    assign code_ext = RATIO_W'(code);

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_rule
        if (m == int'(TBL_DOUBLE)) begin : g_double
            // Doubling rule: 2 * (code + 1).
            assign cand[m] = (code_ext + ONE) << 1;
        end else if (m == int'(TBL_QUAD)) begin : g_quad
            // Quadrupling rule: 4 * (code + 1).
            assign cand[m] = (code_ext + ONE) << 2;
        end else if (m == int'(TBL_ENGINE)) begin : g_engine
            // Engine rule: the two lowest codes share ratio 2, then code + 1.
            assign cand[m] = (code_ext < TWO) ? TWO : (code_ext + ONE);
        end else begin : g_network
            // Network rule: the two lowest codes share ratio 4, then 2 * code.
            assign cand[m] = (code_ext < TWO) ? FOUR : (code_ext << 1);
        end
    end

    // Pick the candidate for the active rule.
    assign ratio = cand[mode];

endmodule

// File: rtl/cdiv_src_pick.sv
// cdiv_src_pick: gives out the strobe of the applied source, and works out
// which source is to be applied at the next boundary. A request that is out
// of range keeps the applied source. Assumes NUM_SRC <= 2**SEL_W.
module cdiv_src_pick #(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   app_src,
    input  logic [SEL_W-1:0]   req_sel,
    output logic               tick_sel,
    output logic [SEL_W-1:0]   next_src
);

    localparam logic [SEL_W:0] SRC_LIMIT = (SEL_W+1)'(NUM_SRC);

    logic [NUM_SRC-1:0] hit;
    logic               req_ok;

    // One match term per source; at most one can be set.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_hit
        assign hit[s] = src_tick[s] && (app_src == SEL_W'(s));
    end

    // Strobe of the applied source.
    assign tick_sel = |hit;

    // A request counts only when it names an existing source.
    assign req_ok   = {1'b0, req_sel} < SRC_LIMIT;
    assign next_src = req_ok ? req_sel : app_src;

endmodule

// File: rtl/cdiv_core.sv
// cdiv_core: the down-counter with boundary-latched settings. At each
// boundary it latches the ratio and the source that arrive on its inputs,
// reloads with ratio - 1, and raises the pulse for one cycle. In every other
// cycle it counts only on the qualified strobe. Assumes an incoming ratio of
// at least 2, so a pulse is always followed by a low cycle.
module cdiv_core
    import tbl_clk_div_pkg::*;
#(
    parameter int RATIO_W = 6,
    parameter int SEL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [RATIO_W-1:0] next_ratio,
    input  logic [SEL_W-1:0]   next_src,
    output logic               pulse,
    output logic [RATIO_W-1:0] app_ratio,
    output logic [SEL_W-1:0]   app_src
);

    localparam logic [RATIO_W-1:0] RST_RATIO = RATIO_W'(RESET_RATIO);
    localparam logic [RATIO_W-1:0] ONE       = RATIO_W'(1);

    logic [RATIO_W-1:0] cnt;
    logic               at_edge;

    // A boundary is the last strobe of the running period.
    assign at_edge = tick && (cnt == '0);

    // Count strobes, and latch new settings only at a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= RST_RATIO - ONE;
            app_ratio <= RST_RATIO;
            app_src   <= SEL_W'(RESET_SOURCE);
            pulse     <= 1'b0;
        end else begin
            pulse <= at_edge;
            if (at_edge) begin
                cnt       <= next_ratio - ONE;
                app_ratio <= next_ratio;
                app_src   <= next_src;
            end else if (tick) begin
                cnt <= cnt - ONE;
            end
        end
    end

    // R6: the pulse never lasts two cycles.
    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    // R9: a pulse is always preceded by a strobe of the applied source.
    p_pulse_needs_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> $past(tick));

    // R7: the applied settings move only together with a pulse.
    p_hold_between_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pulse |-> ($stable(app_ratio) && $stable(app_src)));

    // R6: the counter never starts a period longer than the applied ratio.
    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < app_ratio);

endmodule

// File: rtl/tbl_clk_div.sv
// tbl_clk_div: top level of the table-encoded clock-enable divider. It
// connects the ratio table, the source picker and the counter core. All
// settings are sampled every cycle, but they are committed only at a
// boundary. Assumes the source strobes are synchronous to clk.
module tbl_clk_div
    import tbl_clk_div_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2,
    parameter int CODE_W  = 3,
    parameter int RATIO_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [CODE_W-1:0]  div_code,
    input  logic [1:0]         tbl_mode,
    output logic               div_pulse,
    output logic [RATIO_W-1:0] cur_ratio,
    output logic [SEL_W-1:0]   cur_src
);

    localparam logic [SEL_W-1:0] SRC_LIMIT = SEL_W'(NUM_SRC);

    tbl_mode_e          mode_q;
    logic [RATIO_W-1:0] lut_ratio;
    logic [SEL_W-1:0]   nxt_src;
    logic               sel_tick;

    // Reinterpret the raw mode bits as a table rule.
    assign mode_q = tbl_mode_e'(tbl_mode);

    cdiv_ratio_lut #(
        .CODE_W  (CODE_W),
        .RATIO_W (RATIO_W)
    ) u_lut (
        .code  (div_code),
        .mode  (mode_q),
        .ratio (lut_ratio)
    );

    cdiv_src_pick #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) u_pick (
        .src_tick (src_tick),
        .app_src  (cur_src),
        .req_sel  (src_sel),
        .tick_sel (sel_tick),
        .next_src (nxt_src)
    );

    cdiv_core #(
        .RATIO_W (RATIO_W),
        .SEL_W   (SEL_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sel_tick),
        .next_ratio (lut_ratio),
        .next_src   (nxt_src),
        .pulse      (div_pulse),
        .app_ratio  (cur_ratio),
        .app_src    (cur_src)
    );

    // R8: the applied source is always an existing one.
    p_src_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src < SRC_LIMIT);

    // R8: a boundary with an invalid request keeps the source.
    p_bad_sel_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (div_pulse && ($past(src_sel) >= SRC_LIMIT)) |-> (cur_src == $past(cur_src)));

    // R6: the applied ratio stays within the span that all tables share.
    p_ratio_span_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_ratio >= RATIO_W'(2)) && (cur_ratio <= RATIO_W'(32)));

endmodule

// File: tb/tbl_clk_div_bench.sv
// Bench: directed sweeps of every table entry, followed by seeded random
// stimulus. All of it is compared cycle by cycle against a model written
// from the requirements.
module tbl_clk_div_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_tick = 3'b000;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] div_code = 3'd0;
    logic [1:0] tbl_mode = 2'd0;
    logic       div_pulse;
    logic [5:0] cur_ratio;
    logic [1:0] cur_src;

    int vectors = 0;
    int fails = 0;

    // Model state.
    int m_ratio = 2;
    int m_src = 0;
    int m_cnt = 1;
    int m_pulse = 0;
    int m_amode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbl_clk_div u_tbl_clk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_tick  (src_tick),
        .src_sel   (src_sel),
        .div_code  (div_code),
        .tbl_mode  (tbl_mode),
        .div_pulse (div_pulse),
        .cur_ratio (cur_ratio),
        .cur_src   (cur_src)
    );

    function automatic int exp_ratio(input int m, input int c);
        case (m)
            0: return 2 * (c + 1);
            1: return 4 * (c + 1);
            2: return (c < 2) ? 2 : c + 1;
            default: return (c < 2) ? 4 : 2 * c;
        endcase
    endfunction

    function automatic string mode_tag(input int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL [%s] t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_ratio = 2; m_src = 0; m_cnt = 1; m_pulse = 0; m_amode = 0;
        end else begin
            bit t = src_tick[m_src];
            m_pulse = (t && m_cnt == 0) ? 1 : 0;
            if (m_pulse == 1) begin
                m_ratio = exp_ratio(tbl_mode, div_code);
                m_amode = tbl_mode;
                if (src_sel != 2'd3) m_src = src_sel;
                m_cnt = m_ratio - 1;
            end else if (t) begin
                m_cnt = m_cnt - 1;
            end
        end
        @(negedge clk);
        chk(div_pulse == m_pulse[0], "R6", div_pulse, m_pulse);
        chk(cur_ratio == m_ratio[5:0], mode_tag(m_amode), cur_ratio, m_ratio);
        chk(cur_src == m_src[1:0], "R8", cur_src, m_src);
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!div_pulse && n < 200);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL [R6] watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : main
        int n;
        void'($urandom(32'd4242));
        @(negedge clk);
        repeat (4) step();
        rst_n = 1'b1;
        src_tick = 3'b111;
        step();
        // R1: reset state.
        chk(cur_ratio == 6'd2, "R1", cur_ratio, 2);
        chk(cur_src == 2'd0, "R1", cur_src, 0);
        chk(div_pulse == 1'b0, "R1", div_pulse, 0);

        // R2..R5: every table entry, with the period measured.
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                tbl_mode = m[1:0];
                div_code = c[2:0];
                wait_pulse(n);
                chk(cur_ratio == exp_ratio(m, c), mode_tag(m), cur_ratio, exp_ratio(m, c));
                wait_pulse(n);
                chk(n == exp_ratio(m, c), mode_tag(m), n, exp_ratio(m, c));
            end
        end

        // R7: a change mid-period leaves the running period at its old length.
        tbl_mode = 2'd0; div_code = 3'd7;
        wait_pulse(n);
        wait_pulse(n);
        repeat (3) step();
        div_code = 3'd0;
        wait_pulse(n);
        chk(n + 3 == 16, "R7", n + 3, 16);
        wait_pulse(n);
        chk(n == 2, "R7", n, 2);

        // R9: move to source 1, then strobe only the other sources.
        src_sel = 2'd1;
        wait_pulse(n);
        chk(cur_src == 2'd1, "R8", cur_src, 1);
        src_tick = 3'b101;
        n = 0;
        for (int i = 0; i < 40; i++) begin
            step();
            if (div_pulse) n++;
        end
        chk(n == 0, "R9", n, 0);

        // R8: an invalid request keeps source 1 across boundaries.
        src_tick = 3'b111;
        src_sel = 2'd3;
        wait_pulse(n);
        wait_pulse(n);
        chk(cur_src == 2'd1, "R8", cur_src, 1);

        // Random strobes and reprogramming.
        for (int i = 0; i < 6000; i++) begin
            src_tick = 3'($urandom) | 3'($urandom);
            if (($urandom % 16) == 0) begin
                div_code = 3'($urandom);
                tbl_mode = 2'($urandom);
                src_sel  = 2'($urandom);
            end
            step();
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule